// File: doc/BRIEF.md
# Read-Unlocked Configuration Register Front End

This block sits behind a byte-wide host register bus and holds two configuration registers that share their addresses with two write-only count registers in register page 0. A read at either shared offset always returns the configuration register behind it. A write at that offset reaches the configuration register only when it is the very next register access after a read of the same offset. In every other case the write loads the count register that owns the offset. This keeps a stray write from changing the link setup.

Each shared offset has a one-bit unlock arm. Only a read of that offset in page 0 sets it, and every other access clears it, including a completed unlocked write. The second configuration register also holds a link-change interrupt path. A status bit is set on any edge of the link input, and the host clears it by writing 1 through an unlocked write. The interrupt output is the status bit gated by a mask bit.

Top module: `hidreg_front`

## Requirements
- R1: After reset, mode select reads binary 10, all other configuration outputs are 0, both counts are 0x00 and the interrupt output is low.
- R2: A page-0 read at offset 0xA returns {2'b00, cache_en, decode_full, duplex_full, io16_early, mii_mode[1:0]}. A page-0 read at offset 0xB returns {5'b0, live link level, link-change status, interrupt mask}. Reads at any other offset return 0x00.
- R3: A page-0 write at 0xA that directly follows a page-0 read of 0xA loads data bits [5:0] into configuration A in the field order of R2, and leaves count_lo unchanged.
- R4: A page-0 write at 0xB that directly follows a page-0 read of 0xB loads the mask from data bit 0, clears the link-change status when data bit 1 is 1, and leaves count_hi unchanged.
- R5: A page-0 write at 0xA or 0xB whose previous access was not a read of the same offset loads the whole byte into count_lo (0xA) or count_hi (0xB), and leaves the configuration unchanged. This applies whether the previous access was a different offset, a write, or a read of the other shared offset.
- R6: An unlocked write uses up the unlock, so a second write right behind it goes to the count register.
- R7: Any access with a non-zero page leaves every register unchanged, returns 0x00, and clears both unlock arms.
- R8: Any rising or falling edge of link_in sets the link-change status from the next cycle on. The status stays set until it is cleared as in R4.
- R9: link_irq is high exactly when both the link-change status and the mask are 1.
- R10: Read-only bits ignore writes: configuration A bits [7:6] and configuration B bits [7:2] are unaffected by unlocked writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_en | input | 1 | Register access strobe, one access per cycle |
| acc_wr | input | 1 | 1 = write, 0 = read |
| acc_page | input | 2 | Register page select |
| acc_ofs | input | 4 | Register offset within the page |
| acc_wdata | input | 8 | Write data |
| acc_rdata | output | 8 | Read data, valid in the access cycle |
| link_in | input | 1 | Synchronous link level |
| link_irq | output | 1 | Link-change interrupt |
| mii_mode | output | 2 | Management interface mode select |
| io16_early | output | 1 | Early 16-bit strobe enable |
| duplex_full | output | 1 | 1 = full duplex, 0 = half duplex |
| decode_full | output | 1 | 1 = compare address lines [9:0], 0 = lines [5:0] |
| cache_en | output | 1 | Remote transfer cache enable |
| count_lo | output | 8 | Count register at offset 0xA |
| count_hi | output | 8 | Count register at offset 0xB |

## Verification
On every cycle the assertions check how each write is steered against the state of its unlock arm. They also check that any write, or any access outside page 0, drops the arms. Link edges must set the status, and the interrupt must stay low while the mask is clear. Only the bench's scenarios show the read data layout, the reset values, and the effect of an intervening access on a later write. The same goes for the order of a read of one shared offset followed by a write to the other, and the clearing of status through the unlock path as opposed to a locked write.

// File: rtl/hidreg_pkg.sv
package hidreg_pkg;

    localparam int SLOTS = 2;
    localparam int SLOT_A = 0;
    localparam int SLOT_B = 1;

    typedef struct packed {
        logic       cache;
        logic       decode;
        logic       duplex;
        logic       io16;
        logic [1:0] mii;
    } cfga_t;

    localparam int CFGA_W = $bits(cfga_t);

    localparam cfga_t CFGA_RST = '{cache: 1'b0, decode: 1'b0, duplex: 1'b0,
                                   io16: 1'b0, mii: 2'b10};

endpackage

// File: rtl/hidreg_decode.sv
module hidreg_decode #(
    parameter int OFS_W  = 4,
    parameter int PAGE_W = 2,
    parameter int NSLOT  = 2,
    parameter logic [NSLOT*OFS_W-1:0] SLOT_OFS = '0
) (
    input  logic              acc_en,
    input  logic              acc_wr,
    input  logic [PAGE_W-1:0] acc_page,
    input  logic [OFS_W-1:0]  acc_ofs,
    output logic [NSLOT-1:0]  rd_hit,
    output logic [NSLOT-1:0]  wr_hit
);
    logic page_ok;
    assign page_ok = acc_en && (acc_page == '0);

    for (genvar g = 0; g < NSLOT; g++) begin : g_slot
        logic ofs_eq;
        assign ofs_eq    = (acc_ofs == SLOT_OFS[g*OFS_W +: OFS_W]);
        assign rd_hit[g] = page_ok && !acc_wr && ofs_eq;
        assign wr_hit[g] = page_ok &&  acc_wr && ofs_eq;
    end
endmodule

// File: rtl/hidreg_link.sv
module hidreg_link (
    input  logic clk,
    input  logic rst_n,
    input  logic link_in,
    input  logic clr,
    output logic stat
);
    typedef struct packed {
        logic last;
        logic stat;
    } lk_t;

    lk_t lk_d, lk_q;

    always_comb begin
        lk_d      = lk_q;
        lk_d.last = link_in;
        if (link_in != lk_q.last) begin
            lk_d.stat = 1'b1;
        end else if (clr) begin
            lk_d.stat = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lk_q <= '0;
        end else begin
            lk_q <= lk_d;
        end
    end

    assign stat = lk_q.stat;
endmodule

// File: rtl/hidreg_rdmux.sv
module hidreg_rdmux #(
    parameter int DATA_W = 8,
    parameter int NSLOT  = 2
) (
    input  logic [NSLOT-1:0]        rd_hit,
    input  logic [NSLOT*DATA_W-1:0] slot_val,
    output logic [DATA_W-1:0]       rdata
);
    always_comb begin
        rdata = '0;
        for (int i = 0; i < NSLOT; i++) begin
            if (rd_hit[i]) begin
                rdata = rdata | slot_val[i*DATA_W +: DATA_W];
            end
        end
    end
endmodule

// File: rtl/hidreg_front.sv
module hidreg_front
    import hidreg_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int OFS_W  = 4,
    parameter int PAGE_W = 2,
    parameter logic [OFS_W-1:0] OFS_A = 4'hA,
    parameter logic [OFS_W-1:0] OFS_B = 4'hB
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_en,
    input  logic              acc_wr,
    input  logic [PAGE_W-1:0] acc_page,
    input  logic [OFS_W-1:0]  acc_ofs,
    input  logic [DATA_W-1:0] acc_wdata,
    output logic [DATA_W-1:0] acc_rdata,
    input  logic              link_in,
    output logic              link_irq,
    output logic [1:0]        mii_mode,
    output logic              io16_early,
    output logic              duplex_full,
    output logic              decode_full,
    output logic              cache_en,
    output logic [DATA_W-1:0] count_lo,
    output logic [DATA_W-1:0] count_hi
);
    localparam logic [SLOTS*OFS_W-1:0] SLOT_OFS = {OFS_B, OFS_A};
    localparam int PAD_A = DATA_W - CFGA_W;
    localparam int PAD_B = DATA_W - 3;

    typedef struct packed {
        cfga_t              cfga;
        logic               mask;
        logic [SLOTS-1:0]   arm;
        logic [DATA_W-1:0]  cnt_lo;
        logic [DATA_W-1:0]  cnt_hi;
    } st_t;

    st_t  st_d, st_q;
    logic stat_clr;
    logic stat;

    logic [SLOTS-1:0]        rd_hit;
    logic [SLOTS-1:0]        wr_hit;
    logic [SLOTS-1:0]        arm;
    logic [DATA_W-1:0]       cfga_byte;
    logic [DATA_W-1:0]       cfgb_byte;
    logic [SLOTS*DATA_W-1:0] slot_val;

    hidreg_decode #(
        .OFS_W   (OFS_W),
        .PAGE_W  (PAGE_W),
        .NSLOT   (SLOTS),
        .SLOT_OFS(SLOT_OFS)
    ) u_decode (
        .acc_en  (acc_en),
        .acc_wr  (acc_wr),
        .acc_page(acc_page),
        .acc_ofs (acc_ofs),
        .rd_hit  (rd_hit),
        .wr_hit  (wr_hit)
    );

    always_comb begin
        st_d     = st_q;
        stat_clr = 1'b0;
        if (acc_en) begin
            // Only a page-0 read of a shared offset arms it; all else disarms.
            st_d.arm = rd_hit;
        end
        if (wr_hit[SLOT_A]) begin
            if (st_q.arm[SLOT_A]) begin
                st_d.cfga = cfga_t'(acc_wdata[CFGA_W-1:0]);
            end else begin
                st_d.cnt_lo = acc_wdata;
            end
        end
        if (wr_hit[SLOT_B]) begin
            if (st_q.arm[SLOT_B]) begin
                st_d.mask = acc_wdata[0];
                stat_clr  = acc_wdata[1];
            end else begin
                st_d.cnt_hi = acc_wdata;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q      <= '0;
            st_q.cfga <= CFGA_RST;
        end else begin
            st_q <= st_d;
        end
    end

    hidreg_link u_link (
        .clk    (clk),
        .rst_n  (rst_n),
        .link_in(link_in),
        .clr    (stat_clr),
        .stat   (stat)
    );

    assign cfga_byte = {{PAD_A{1'b0}}, st_q.cfga};
    assign cfgb_byte = {{PAD_B{1'b0}}, link_in, stat, st_q.mask};
    assign slot_val  = {cfgb_byte, cfga_byte};
    assign arm       = st_q.arm;

    hidreg_rdmux #(
        .DATA_W(DATA_W),
        .NSLOT (SLOTS)
    ) u_rdmux (
        .rd_hit  (rd_hit),
        .slot_val(slot_val),
        .rdata   (acc_rdata)
    );

    assign link_irq    = stat & st_q.mask;
    assign mii_mode    = st_q.cfga.mii;
    assign io16_early  = st_q.cfga.io16;
    assign duplex_full = st_q.cfga.duplex;
    assign decode_full = st_q.cfga.decode;
    assign cache_en    = st_q.cfga.cache;
    assign count_lo    = st_q.cnt_lo;
    assign count_hi    = st_q.cnt_hi;
endmodule

// File: rtl/hidreg_front_chk.sv
module hidreg_front_chk #(
    parameter int DATA_W = 8,
    parameter int PAGE_W = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              acc_en,
    input logic              acc_wr,
    input logic [PAGE_W-1:0] acc_page,
    input logic [DATA_W-1:0] acc_wdata,
    input logic              link_in,
    input logic              link_irq,
    input logic [1:0]        wr_hit,
    input logic [1:0]        arm,
    input logic [DATA_W-1:0] cfga_byte,
    input logic [DATA_W-1:0] cfgb_byte,
    input logic [DATA_W-1:0] count_lo,
    input logic [DATA_W-1:0] count_hi
);
    assert_locked_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_hit[0] && !arm[0]) |=> (count_lo == $past(acc_wdata)) && $stable(cfga_byte));

    assert_unlocked_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_hit[0] && arm[0]) |=> $stable(count_lo) && (cfga_byte[5:0] == $past(acc_wdata[5:0])));

    assert_unlocked_mask_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_hit[1] && arm[1]) |=> $stable(count_hi) && (cfgb_byte[0] == $past(acc_wdata[0])));

    assert_arm_consumed_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_en && acc_wr) |=> (arm == 2'b00));

    assert_other_page_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_en && acc_page != '0) |=> $stable(count_lo) && $stable(count_hi)
                                       && $stable(cfga_byte) && (arm == 2'b00));

    assert_link_edge_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(link_in) |=> cfgb_byte[1]);

    assert_mask_gate_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !cfgb_byte[0] |-> !link_irq);
endmodule

bind hidreg_front hidreg_front_chk #(.DATA_W(DATA_W), .PAGE_W(PAGE_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .acc_en   (acc_en),
    .acc_wr   (acc_wr),
    .acc_page (acc_page),
    .acc_wdata(acc_wdata),
    .link_in  (link_in),
    .link_irq (link_irq),
    .wr_hit   (wr_hit),
    .arm      (arm),
    .cfga_byte(cfga_byte),
    .cfgb_byte(cfgb_byte),
    .count_lo (count_lo),
    .count_hi (count_hi)
);

// File: tb/hidreg_front_bench.sv
module hidreg_front_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       acc_en = 1'b0;
    logic       acc_wr = 1'b0;
    logic [1:0] acc_page = '0;
    logic [3:0] acc_ofs = '0;
    logic [7:0] acc_wdata = '0;
    logic [7:0] acc_rdata;
    logic       link_in = 1'b0;
    logic       link_irq;
    logic [1:0] mii_mode;
    logic       io16_early, duplex_full, decode_full, cache_en;
    logic [7:0] count_lo, count_hi;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    hidreg_front u_hidreg_front (
        .clk(clk), .rst_n(rst_n), .acc_en(acc_en), .acc_wr(acc_wr),
        .acc_page(acc_page), .acc_ofs(acc_ofs), .acc_wdata(acc_wdata),
        .acc_rdata(acc_rdata), .link_in(link_in), .link_irq(link_irq),
        .mii_mode(mii_mode), .io16_early(io16_early), .duplex_full(duplex_full),
        .decode_full(decode_full), .cache_en(cache_en),
        .count_lo(count_lo), .count_hi(count_hi)
    );

    // what: 1 = read data, 2 = configuration A outputs, 3 = count_lo, 4 = count_hi
    typedef struct packed {
        logic       wr;
        logic [1:0] page;
        logic [3:0] ofs;
        logic [7:0] wdata;
        logic [2:0] what;
        logic [7:0] exp;
        logic [3:0] req;
    } vec_t;

    localparam int NV = 20;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 2'd0, 4'hA, 8'h00, 3'd1, 8'h02, 4'd2},   // R2 reset value via read
        '{1'b1, 2'd0, 4'hA, 8'h3D, 3'd2, 8'h3D, 4'd3},   // R3 unlocked write
        '{1'b1, 2'd0, 4'hA, 8'h55, 3'd3, 8'h55, 4'd6},   // R6 second write -> count
        '{1'b0, 2'd0, 4'hA, 8'h00, 3'd1, 8'h3D, 4'd6},   // R6 config kept
        '{1'b0, 2'd0, 4'h3, 8'h00, 3'd1, 8'h00, 4'd2},   // R2 other offset reads 0
        '{1'b1, 2'd0, 4'hA, 8'hC7, 3'd3, 8'hC7, 4'd5},   // R5 intervening access
        '{1'b1, 2'd0, 4'hB, 8'h9A, 3'd4, 8'h9A, 4'd5},   // R5 no read at all
        '{1'b0, 2'd0, 4'hA, 8'h00, 3'd1, 8'h3D, 4'd5},
        '{1'b1, 2'd0, 4'hB, 8'h11, 3'd4, 8'h11, 4'd5},   // R5 read of other slot
        '{1'b0, 2'd0, 4'hB, 8'h00, 3'd1, 8'h00, 4'd2},   // R2 config B layout
        '{1'b1, 2'd0, 4'hB, 8'hFD, 3'd4, 8'h11, 4'd4},   // R4 count_hi untouched
        '{1'b0, 2'd0, 4'hB, 8'h00, 3'd1, 8'h01, 4'd10},  // R10 bits 7:2 ignored
        '{1'b0, 2'd1, 4'hA, 8'h00, 3'd1, 8'h00, 4'd7},   // R7 page 1 reads 0
        '{1'b1, 2'd0, 4'hA, 8'h22, 3'd3, 8'h22, 4'd7},   // R7 page-1 read did not arm
        '{1'b0, 2'd0, 4'hA, 8'h00, 3'd1, 8'h3D, 4'd7},
        '{1'b1, 2'd2, 4'hA, 8'h00, 3'd3, 8'h22, 4'd7},   // R7 page 2 write ignored
        '{1'b1, 2'd0, 4'hA, 8'h00, 3'd3, 8'h00, 4'd7},   // R7 arm cleared by page 2
        '{1'b0, 2'd0, 4'hA, 8'h00, 3'd1, 8'h3D, 4'd10},
        '{1'b1, 2'd0, 4'hA, 8'hFF, 3'd2, 8'h3F, 4'd10},  // R10 bits 7:6 ignored
        '{1'b0, 2'd0, 4'hA, 8'h00, 3'd1, 8'h3F, 4'd10}
    };

    function automatic logic [7:0] cfga_obs();
        return {2'b00, cache_en, decode_full, duplex_full, io16_early, mii_mode};
    endfunction

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual 0x%02h expected 0x%02h", tag, act, exp);
        end
    endtask

    // Drive one access at a falling edge, sample read data before the rising
    // edge, and return at the next falling edge with the strobe dropped.
    task automatic op(input logic wr, input logic [1:0] pg, input logic [3:0] ofs,
                      input logic [7:0] wd, output logic [7:0] rd);
        @(negedge clk);
        acc_en = 1'b1; acc_wr = wr; acc_page = pg; acc_ofs = ofs; acc_wdata = wd;
        #2;
        rd = acc_rdata;
        @(negedge clk);
        acc_en = 1'b0; acc_wr = 1'b0;
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [7:0] rd;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 cfgA", cfga_obs(), 8'h02);
        check("R1 count_lo", count_lo, 8'h00);
        check("R1 count_hi", count_hi, 8'h00);
        check("R1 irq", {7'b0, link_irq}, 8'h00);

        for (int i = 0; i < NV; i++) begin
            vec_t v;
            string tag;
            v = VECS[i];
            op(v.wr, v.page, v.ofs, v.wdata, rd);
            tag = $sformatf("R%0d vec%0d", v.req, i);
            case (v.what)
                3'd1: check(tag, rd, v.exp);
                3'd2: check(tag, cfga_obs(), v.exp);
                3'd3: check(tag, count_lo, v.exp);
                3'd4: check(tag, count_hi, v.exp);
                default: ;
            endcase
        end

        // Mask is 1, status 0, link 0. Rising link edge.
        @(negedge clk); link_in = 1'b1;
        @(negedge clk);
        check("R8 rise sets irq", {7'b0, link_irq}, 8'h01);
        op(1'b0, 2'd0, 4'hB, 8'h00, rd);
        check("R2 cfgB with link up", rd, 8'h07);
        op(1'b1, 2'd0, 4'hB, 8'h03, rd);
        check("R4 unlocked clear", {7'b0, link_irq}, 8'h00);
        // Falling edge.
        @(negedge clk); link_in = 1'b0;
        @(negedge clk);
        check("R8 fall sets irq", {7'b0, link_irq}, 8'h01);
        op(1'b0, 2'd0, 4'hB, 8'h00, rd);
        op(1'b1, 2'd0, 4'hB, 8'h00, rd);
        check("R9 mask off gates irq", {7'b0, link_irq}, 8'h00);
        op(1'b0, 2'd0, 4'hB, 8'h00, rd);
        check("R8 status held", rd, 8'h02);
        // Locked write with clear bit goes to the count, status survives.
        op(1'b0, 2'd0, 4'hA, 8'h00, rd);
        op(1'b1, 2'd0, 4'hB, 8'h02, rd);
        check("R5 locked write to count_hi", count_hi, 8'h02);
        op(1'b0, 2'd0, 4'hB, 8'h00, rd);
        check("R5 status not cleared", rd, 8'h02);
        // Re-enable mask: interrupt returns since status stayed set.
        op(1'b1, 2'd0, 4'hB, 8'h01, rd);
        check("R9 mask on raises irq", {7'b0, link_irq}, 8'h01);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule